// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a slave on a two-wire serial bus. It gives an external host read and write access to a bank of 8-bit control registers that sit in the surrounding core. The clock and data lines are brought into a faster system clock through synchroniser flops, and all bus events are found as edges in that domain. The block pulls the data line low through an open-drain enable and never drives it high.

The seven-bit device address is `1101010` or `1101011`: its lowest bit is taken from a strap input, so the 8-bit write address is 0xD4 or 0xD6. After the address byte, a write carries a subaddress byte and then data bytes. The data bytes land at ascending register indices through a one-cycle write strobe. A read first sets the subaddress with a write, then issues a repeated start with the direction bit set. Bytes are then returned from the retained pointer. The core supplies read data combinationally for the index the block presents.

Invalid subaddresses are refused. These are indices above the top register and indices marked reserved. A write that runs past the top register is refused and the block drops to idle. A read that runs past the top keeps returning the top register. A start or stop seen anywhere abandons the transfer in progress.

Top module: `i2c_regport`

## Requirements
- R1: After reset the data-line enable `sda_oe` is low and no write strobe is issued until a transfer addresses the block.
- R2: The block acknowledges an address byte only when its upper seven bits equal `110101` followed by the `addr_strap` value. It therefore answers 0xD4/0xD5 with the strap low and 0xD6/0xD7 with the strap high. Any other address gets no acknowledge.
- R3: In a write, the byte after the address is the subaddress. Each acknowledged data byte produces exactly one single-cycle `reg_wr` pulse with `reg_addr` at the target index and `reg_wdata` holding the byte, issued while SCL is low.
- R4: Successive data bytes in one write go to successive indices, starting at the subaddress.
- R5: A subaddress above `TOP_SUB` (default 0x3F), or one marked in `RSV_MASK` (default: 0x30 only), gets no acknowledge and the block returns to idle. A data byte whose auto-incremented index is reserved is likewise refused and not stored.
- R6: After a byte is written to index `TOP_SUB`, the next data byte in the same write is refused, is not stored, and every later byte of that transfer is also refused.
- R7: After a repeated start with the direction bit at 1, the block returns the register contents MSB first. It starts at the retained subaddress and moves up one index for each byte the master acknowledges.
- R8: A read that reaches index `TOP_SUB` keeps returning that register for every further byte.
- R9: When the master does not acknowledge a read byte, the block releases the data line and does not start another byte.
- R10: A stop or start condition in the middle of a byte ends the transfer, and the partial byte is not written. A start condition begins a new address phase.
- R11: `sda_oe` is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| addr_strap | input | 1 | Selects the lowest bit of the device address |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | AW (6) | Register index for writes and for read data |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, supplied by the core |

## Verification
On every cycle, the assertions check the following:
- `sda_oe` only rises while SCL is low.
- Write strobes last one cycle and fall in the SCL-low phase.
- A detected stop leaves the data line released and the strobe idle on the next cycle.

The remaining behaviour depends on whole byte sequences, so only the bench's scenarios can show it. This covers strap-dependent address matching, auto-increment, refusal of out-of-range and reserved indices, refusal of writes past the top, saturation of reads, the master's final no-acknowledge, and transfers cut short by stray start or stop conditions. The bench's reference model predicts each acknowledge bit, each strobe and each returned byte.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } xfer_st_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
      logic sda;
   } line_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import i2c_regport_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output line_ev_t ev
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_q;
   logic                   sda_q;
   logic                   scl_s;
   logic                   sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s = scl_pipe[SYNC_STAGES-1];
   assign sda_s = sda_pipe[SYNC_STAGES-1];

   always_comb begin
      ev.scl_rise = scl_s & ~scl_q;
      ev.scl_fall = ~scl_s & scl_q;
      ev.start    = scl_s & scl_q & sda_q & ~sda_s;
      ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
      ev.sda      = sda_s;
   end

endmodule

// File: rtl/i2c_subaddr_check.sv
module i2c_subaddr_check #(
   parameter int                 TOP_SUB  = 63,
   parameter logic [TOP_SUB:0]   RSV_MASK = '0
) (
   input  logic [7:0] sub,
   output logic       ok
);

   localparam int NREG    = TOP_SUB + 1;
   localparam bit HAS_RSV = |RSV_MASK;

   logic in_range;
   assign in_range = (sub <= 8'(TOP_SUB));

   if (HAS_RSV) begin : g_masked
      logic [NREG-1:0] hit;
      for (genvar i = 0; i < NREG; i++) begin : g_hit
         assign hit[i] = RSV_MASK[i] && (sub == 8'(i));
      end
      assign ok = in_range && !(|hit);
   end else begin : g_plain
      assign ok = in_range;
   end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_regport_pkg::*;
#(
   parameter int         TOP_SUB   = 63,
   parameter logic [5:0] DEV_ID_HI = 6'b110101,
   parameter int         AW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  line_ev_t      ev,
   input  logic          addr_strap,
   input  logic          sub_ok,
   output logic [7:0]    sub_cand,
   output logic          sda_oe,
   output logic          reg_wr,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   input  logic [7:0]    reg_rdata
);

   localparam logic [7:0] TOP_IDX = 8'(TOP_SUB);

   xfer_st_e   st;
   logic [7:0] shreg;
   logic [7:0] rbuf;
   logic [7:0] ptr;
   logic [3:0] cnt;
   logic       rw;
   logic       over;
   logic       rx_phase;
   logic [2:0] bit_sel;

   assign rx_phase = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WDATA);
   assign bit_sel  = 3'd7 - cnt[2:0];
   assign sub_cand = (st == ST_SUB) ? shreg : ptr;
   assign reg_addr = ptr[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         shreg     <= '0;
         rbuf      <= '0;
         ptr       <= '0;
         cnt       <= '0;
         rw        <= 1'b0;
         over      <= 1'b0;
         sda_oe    <= 1'b0;
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= 1'b0;
         if (ev.start) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            if (ev.scl_rise && rx_phase) begin
               shreg <= {shreg[6:0], ev.sda};
               cnt   <= cnt + 4'd1;
            end
            if (ev.scl_rise && st == ST_RDATA) begin
               cnt <= cnt + 4'd1;
            end
            if (ev.scl_rise && st == ST_RDATA_ACK) begin
               if (ev.sda) begin
                  st <= ST_IDLE;
               end else if (ptr != TOP_IDX) begin
                  ptr <= ptr + 8'd1;
               end
            end
            if (ev.scl_fall) begin
               unique case (st)
                  ST_ADDR: if (cnt == 4'd8) begin
                     if (shreg[7:1] == {DEV_ID_HI, addr_strap}) begin
                        rw     <= shreg[0];
                        sda_oe <= 1'b1;
                        st     <= ST_ADDR_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_ADDR_ACK: begin
                     cnt <= '0;
                     if (rw) begin
                        rbuf   <= reg_rdata;
                        sda_oe <= ~reg_rdata[7];
                        st     <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_SUB;
                     end
                  end
                  ST_SUB: if (cnt == 4'd8) begin
                     if (sub_ok) begin
                        ptr    <= shreg;
                        over   <= 1'b0;
                        sda_oe <= 1'b1;
                        st     <= ST_SUB_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_SUB_ACK: begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_WDATA;
                  end
                  ST_WDATA: if (cnt == 4'd8) begin
                     if (sub_ok && !over) begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= shreg;
                        sda_oe    <= 1'b1;
                        st        <= ST_WDATA_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_WDATA_ACK: begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_WDATA;
                     if (ptr == TOP_IDX) over <= 1'b1;
                     else                ptr  <= ptr + 8'd1;
                  end
                  ST_RDATA: begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        st     <= ST_RDATA_ACK;
                     end else begin
                        sda_oe <= ~rbuf[bit_sel];
                     end
                  end
                  ST_RDATA_ACK: begin
                     cnt    <= '0;
                     rbuf   <= reg_rdata;
                     sda_oe <= ~reg_rdata[7];
                     st     <= ST_RDATA;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter int               TOP_SUB     = 63,
   parameter logic [TOP_SUB:0] RSV_MASK    = 64'h0001_0000_0000_0000,
   parameter logic [5:0]       DEV_ID_HI   = 6'b110101,
   parameter int               SYNC_STAGES = 2,
   localparam int              AW          = (TOP_SUB > 0) ? $clog2(TOP_SUB + 1) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic          addr_strap,
   output logic          sda_oe,
   output logic          reg_wr,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   input  logic [7:0]    reg_rdata
);

   if (TOP_SUB < 1 || TOP_SUB > 255) begin : g_bad_top
      $error("i2c_regport: TOP_SUB must lie in 1..255");
   end

   line_ev_t   line_ev;
   logic [7:0] sub_cand;
   logic       sub_ok;

   i2c_line_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (line_ev)
   );

   i2c_subaddr_check #(
      .TOP_SUB (TOP_SUB),
      .RSV_MASK(RSV_MASK)
   ) u_subchk (
      .sub (sub_cand),
      .ok  (sub_ok)
   );

   i2c_slave_fsm #(
      .TOP_SUB  (TOP_SUB),
      .DEV_ID_HI(DEV_ID_HI),
      .AW       (AW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (line_ev),
      .addr_strap(addr_strap),
      .sub_ok    (sub_ok),
      .sub_cand  (sub_cand),
      .sda_oe    (sda_oe),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic reg_wr,
   input logic stop_det
);

   // R11
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R3
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   // R3
   wr_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !scl_i);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R10
   stop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !reg_wr);

endmodule

bind i2c_regport i2c_regport_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .sda_oe  (sda_oe),
   .reg_wr  (reg_wr),
   .stop_det(line_ev.stop)
);

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int TOP        = 63;
   localparam int RSV        = 8'h30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       strap = 1'b0;
   logic       sda_line;
   logic       sda_oe;
   logic       reg_wr;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;

   logic [7:0]  bank  [64];
   logic [7:0]  model [64];
   logic [13:0] exp_q [$];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic        oe_prev = 1'b0;
   logic [13:0] exp_w;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = bank[reg_addr];

   i2c_regport u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .addr_strap(strap),
      .sda_oe    (sda_oe),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [7:0] init_val(int i);
      return 8'(i) ^ 8'h5A;
   endfunction

   function automatic bit valid(int a);
      return (a <= TOP) && (a != RSV);
   endfunction

   // core-side register bank
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) bank[i] <= init_val(i);
      end else if (reg_wr) begin
         bank[reg_addr] <= reg_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // per-clock comparison against the model's expected strobe queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
               exp_w = exp_q.pop_front();
               chk({reg_addr, reg_wdata} == exp_w, "R3 strobe", {reg_addr, reg_wdata}, exp_w);
            end
         end
         if (sda_oe && !oe_prev) chk(!scl_m, "R11 oe with SCL high", scl_m, 0);
      end
      oe_prev = sda_oe;
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_io(input bit b, output bit s);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      s = sda_line; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) bit_io(v[i], s);
      bit_io(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, s);
         v[i] = s;
      end
      bit_io(~mack, s);
   endtask

   function automatic logic [7:0] dev_w();
      return {6'b110101, strap, 1'b0};
   endfunction

   task automatic wr_burst(input logic [7:0] dev, input logic [7:0] sub,
                           input logic [7:0] data[$], input string tag);
      bit ack, expa, over;
      int p;
      i2c_start();
      send_byte(dev, ack);
      expa = (dev[7:1] == {6'b110101, strap}) && !dev[0];
      chk(ack == expa, "R2 address ack", ack, expa);
      send_byte(sub, ack);
      expa = expa && valid(int'(sub));
      chk(ack == expa, {tag, " subaddress ack"}, ack, expa);
      p = int'(sub);
      over = 1'b0;
      foreach (data[k]) begin
         expa = expa && !over && valid(p);
         if (expa) begin
            exp_q.push_back({p[5:0], data[k]});
            model[p] = data[k];
         end
         send_byte(data[k], ack);
         chk(ack == expa, {tag, " data ack"}, ack, expa);
         if (expa) begin
            if (p == TOP) over = 1'b1;
            else          p++;
         end
      end
      i2c_stop();
   endtask

   task automatic rd_burst(input logic [7:0] sub, input int n, input string tag);
      bit ack, s;
      int p;
      logic [7:0] v;
      i2c_start();
      send_byte(dev_w(), ack);
      chk(ack, "R7 address ack", ack, 1);
      send_byte(sub, ack);
      chk(ack, "R7 subaddress ack", ack, 1);
      i2c_start();
      send_byte(dev_w() | 8'h01, ack);
      chk(ack, "R7 read address ack", ack, 1);
      p = int'(sub);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n - 1, v);
         chk(v == model[p], {tag, " read data"}, v, model[p]);
         if (p < TOP) p++;
      end
      bit_io(1'b1, s);
      chk(s == 1'b1, "R9 line released after master nack", s, 1);
      i2c_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ack, s;
      for (int i = 0; i < 64; i++) model[i] = init_val(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1
      chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
      chk(reg_wr == 1'b0, "R1 reset strobe", reg_wr, 0);
      wq();

      // R3 / R4: burst write with strap low at 0xD4
      wr_burst(8'hD4, 8'h05, '{8'h21, 8'h32, 8'h43}, "R4");

      // R2: the other strap address is not answered
      wr_burst(8'hD6, 8'h10, '{8'h5A}, "R2");
      strap = 1'b1;
      wq();
      wr_burst(8'hD6, 8'h10, '{8'h5A}, "R2");
      rd_burst(8'h10, 1, "R2");
      wr_burst(8'hD4, 8'h11, '{8'h66}, "R2");
      strap = 1'b0;
      wq();

      // R5: out-of-range and reserved subaddresses, increment into reserved
      wr_burst(8'hD4, 8'h40, '{8'h12}, "R5");
      wr_burst(8'hD4, 8'h30, '{8'h12}, "R5");
      wr_burst(8'hD4, 8'h2F, '{8'h77, 8'h88}, "R5");

      // R6: write overrun past the top register
      wr_burst(8'hD4, 8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6");

      // R7 / R9: read back the burst
      rd_burst(8'h05, 3, "R7");

      // R8: read saturates at the top register
      rd_burst(8'h3E, 4, "R8");

      // R10: stop in the middle of a data byte
      i2c_start();
      send_byte(dev_w(), ack);
      send_byte(8'h08, ack);
      for (int i = 0; i < 4; i++) bit_io(1'b1, s);
      i2c_stop();
      chk(exp_q.size() == 0, "R10 no write after mid-byte stop", exp_q.size(), 0);

      // R10: start in the middle of a data byte restarts the address phase
      i2c_start();
      send_byte(dev_w(), ack);
      send_byte(8'h09, ack);
      for (int i = 0; i < 5; i++) bit_io(1'b0, s);
      wr_burst(8'hD4, 8'h0A, '{8'h99}, "R10");
      rd_burst(8'h08, 3, "R10");

      wq();
      chk(exp_q.size() == 0, "R3 all expected strobes seen", exp_q.size(), 0);
      for (int i = 0; i < 64; i++)
         chk(bank[i] == model[i], "R6 bank contents", bank[i], model[i]);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule